// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block makes the keep-or-drop decision for a received Ethernet frame once the frame has ended. At the end of the frame it takes the destination address, the frame length and the two receive error flags. It then judges them against its own configuration. That configuration is a 48-bit station address, a 64-bin multicast hash table, and five acceptance switches: broadcast, multicast, promiscuous, short frames and errored frames.

One clock after the end-of-frame strobe, the block returns an accept bit and a status byte. The status byte records the error flags, the short-frame condition and whether the destination was a group (multicast or broadcast) address or an individual one. A downstream storage engine uses the accept bit to commit or discard the buffered frame, and it stores the status byte with the frame.

The configuration is loaded one byte at a time through a small write port. The frame store and the payload CRC checker sit outside this block.

Top module: `rxf_addr_filter`

## Requirements
- R1: After reset, res_valid, res_accept and res_status are all zero, and the station address, the hash table and all mode switches are zero.
- R2: Each cycle with eof_valid high produces exactly one cycle of res_valid high on the following clock, carrying that frame's accept bit and status byte. When res_valid is low, res_accept and res_status are zero.
- R3: An individual destination (dst_addr bit 0 clear; the first address byte is dst_addr[7:0]) is accepted, when promiscuous mode is off, only if all 48 bits equal the station address.
- R4: With promiscuous mode on, every individual destination is accepted. Promiscuous mode does not accept group destinations.
- R5: The all-ones destination is accepted only when broadcast acceptance is on. The multicast switch and the hash table have no effect on it.
- R6: A group destination other than all-ones is accepted only when multicast acceptance is on and its hash bit is set. The bin is found by running a 32-bit register, preset to all ones, over dst_addr bits 0 to 47 in ascending order. Each step computes f = reg[0] xor bit, shifts the register right by one, and XORs in 32'hEDB88320 when f is 1. The bin is {reg[0],reg[1],reg[2],reg[3],reg[4],reg[5]}, and hash bit n lives in hash byte n/8 at position n%8.
- R7: A frame shorter than 64 bytes is rejected unless short-frame acceptance is on. A length of exactly 64 bytes counts as normal.
- R8: A frame with the CRC error flag or the alignment error flag set is rejected unless errored-frame saving is on.
- R9: Status layout: bit 0 is set when the frame is accepted with neither error flag; bit 1 is set when the CRC flag or the alignment flag is set; bit 2 is the alignment flag; bit 3 marks a frame shorter than 64 bytes; bit 4 is dst_addr bit 0 (0 for an individual match, 1 for a group match); bits 7:5 are zero.
- R10: A write with cfg_wr high stores cfg_data at the edge as follows:
  - cfg_sel 0 to 5 loads station byte k, which is compared against dst_addr[8k+7:8k].
  - cfg_sel 8 to 15 loads hash byte cfg_sel-8.
  - cfg_sel 16 loads the mode switches: bit 0 broadcast, bit 1 multicast, bit 2 promiscuous, bit 3 short frames, bit 4 errored frames.
  - Writes to any other index change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_sel | input | 5 | Configuration byte index |
| cfg_data | input | 8 | Configuration byte value |
| eof_valid | input | 1 | End-of-frame strobe; frame inputs valid |
| dst_addr | input | 48 | Destination address, first byte in bits 7:0 |
| frame_len | input | 16 | Frame length in bytes |
| crc_err | input | 1 | Frame failed its CRC check |
| align_err | input | 1 | Frame did not end on a byte boundary |
| res_valid | output | 1 | Decision valid strobe |
| res_accept | output | 1 | Keep the frame |
| res_status | output | 8 | Status byte (layout in R9) |

## Verification
The assertions assume that the frame inputs are meaningful only in a cycle with eof_valid high. They also assume that the configuration is not rewritten in the same cycle as an end-of-frame strobe, because a frame is judged against the configuration held before that edge. The stimulus keeps to both assumptions. It always finishes each configuration write before it presents a frame, and it lowers eof_valid one cycle later. Every strobe therefore sees a settled configuration and yields exactly one result.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;
   // Acceptance switches; first member is the MSB of the packed word.
   typedef struct packed {
      logic save_err;
      logic runt_ok;
      logic promisc;
      logic mc_en;
      logic bc_en;
   } rxf_mode_t;

   localparam int MODE_W   = 5;
   localparam int STATUS_W = 8;

   localparam int ST_CLEAN = 0;
   localparam int ST_CRC   = 1;
   localparam int ST_ALIGN = 2;
   localparam int ST_RUNT  = 3;
   localparam int ST_GROUP = 4;

   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
endpackage

// File: rtl/rxf_cfg_regs.sv
`timescale 1ns/1ps
module rxf_cfg_regs
   import rxf_pkg::*;
#(
   parameter int N_ADDR_BYTES = 6,
   parameter int N_HASH_BYTES = 8,
   parameter int HASH_BASE    = 8,
   parameter int MODE_SEL     = 16,
   parameter int SEL_W        = 5
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_wr,
   input  logic [SEL_W-1:0]          cfg_sel,
   input  logic [7:0]                cfg_data,
   output logic [8*N_ADDR_BYTES-1:0] station,
   output logic [8*N_HASH_BYTES-1:0] hash_vec,
   output rxf_mode_t                 mode
);
   for (genvar k = 0; k < N_ADDR_BYTES; k++) begin : g_sta
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            station[8*k +: 8] <= '0;
         end else if (cfg_wr && cfg_sel == SEL_W'(k)) begin
            station[8*k +: 8] <= cfg_data;
         end
      end
   end

   for (genvar j = 0; j < N_HASH_BYTES; j++) begin : g_hash
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hash_vec[8*j +: 8] <= '0;
         end else if (cfg_wr && cfg_sel == SEL_W'(HASH_BASE + j)) begin
            hash_vec[8*j +: 8] <= cfg_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= '0;
      end else if (cfg_wr && cfg_sel == SEL_W'(MODE_SEL)) begin
         mode <= rxf_mode_t'(cfg_data[MODE_W-1:0]);
      end
   end
endmodule

// File: rtl/rxf_hash.sv
`timescale 1ns/1ps
module rxf_hash
   import rxf_pkg::*;
#(
   parameter int ADDR_W    = 48,
   parameter int HASH_BITS = 6,
   localparam int HASH_SIZE = 1 << HASH_BITS
)(
   input  logic [ADDR_W-1:0]    dst,
   input  logic [HASH_SIZE-1:0] hash_vec,
   output logic                 hit
);
   // Serial reflected CRC over the address, unrolled into combinational logic.
   function automatic logic [HASH_BITS-1:0] bin_of(input logic [ADDR_W-1:0] a);
      logic [31:0]          c;
      logic [HASH_BITS-1:0] b;
      c = '1;
      for (int i = 0; i < ADDR_W; i++) begin
         logic fb;
         fb = c[0] ^ a[i];
         c  = c >> 1;
         if (fb) c = c ^ CRC_POLY_REFL;
      end
      for (int n = 0; n < HASH_BITS; n++) begin
         b[HASH_BITS-1-n] = c[n];
      end
      return b;
   endfunction

   logic [HASH_BITS-1:0] bin;

   always_comb begin
      bin = bin_of(dst);
      hit = hash_vec[bin];
   end
endmodule

// File: rtl/rxf_decide.sv
`timescale 1ns/1ps
module rxf_decide
   import rxf_pkg::*;
#(
   parameter int ADDR_W  = 48,
   parameter int LEN_W   = 16,
   parameter int MIN_LEN = 64
)(
   input  logic [ADDR_W-1:0]   dst,
   input  logic [LEN_W-1:0]    frame_len,
   input  logic                crc_err,
   input  logic                align_err,
   input  logic [ADDR_W-1:0]   station,
   input  rxf_mode_t           mode,
   input  logic                hash_hit,
   output logic                accept,
   output logic [STATUS_W-1:0] status
);
   logic is_group, is_bcast, is_runt, has_err, addr_ok;

   always_comb begin
      is_group = dst[0];
      is_bcast = &dst;
      is_runt  = frame_len < LEN_W'(MIN_LEN);
      has_err  = crc_err | align_err;

      if (is_bcast) begin
         addr_ok = mode.bc_en;
      end else if (is_group) begin
         addr_ok = mode.mc_en & hash_hit;
      end else begin
         addr_ok = mode.promisc | (dst == station);
      end

      accept = addr_ok & (~is_runt | mode.runt_ok) & (~has_err | mode.save_err);

      status           = '0;
      status[ST_CLEAN] = accept & ~has_err;
      status[ST_CRC]   = has_err;
      status[ST_ALIGN] = align_err;
      status[ST_RUNT]  = is_runt;
      status[ST_GROUP] = is_group;
   end
endmodule

// File: rtl/rxf_addr_filter.sv
`timescale 1ns/1ps
module rxf_addr_filter
   import rxf_pkg::*;
#(
   parameter int ADDR_W    = 48,
   parameter int HASH_BITS = 6,
   parameter int LEN_W     = 16,
   parameter int MIN_LEN   = 64,
   localparam int N_ADDR_BYTES = ADDR_W / 8,
   localparam int N_HASH_BYTES = (1 << HASH_BITS) / 8,
   localparam int HASH_BASE    = 1 << $clog2(N_ADDR_BYTES),
   localparam int MODE_SEL     = HASH_BASE + N_HASH_BYTES,
   localparam int SEL_W        = $clog2(MODE_SEL + 1)
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_wr,
   input  logic [SEL_W-1:0]    cfg_sel,
   input  logic [7:0]          cfg_data,
   input  logic                eof_valid,
   input  logic [ADDR_W-1:0]   dst_addr,
   input  logic [LEN_W-1:0]    frame_len,
   input  logic                crc_err,
   input  logic                align_err,
   output logic                res_valid,
   output logic                res_accept,
   output logic [STATUS_W-1:0] res_status
);
   localparam int HASH_SIZE = 1 << HASH_BITS;

   if (ADDR_W % 8 != 0) begin : g_bad_addr_w
      $error("ADDR_W must be a whole number of bytes");
   end
   if (HASH_BITS < 3 || HASH_BITS > 32) begin : g_bad_hash_bits
      $error("HASH_BITS must lie between 3 and 32");
   end
   if (MIN_LEN >= (1 << LEN_W)) begin : g_bad_min_len
      $error("MIN_LEN does not fit in LEN_W bits");
   end

   logic [ADDR_W-1:0]    station_q;
   logic [HASH_SIZE-1:0] hash_q;
   rxf_mode_t            mode_q;
   logic                 hash_hit;
   logic                 acc_d;
   logic [STATUS_W-1:0]  status_d;

   rxf_cfg_regs #(
      .N_ADDR_BYTES (N_ADDR_BYTES),
      .N_HASH_BYTES (N_HASH_BYTES),
      .HASH_BASE    (HASH_BASE),
      .MODE_SEL     (MODE_SEL),
      .SEL_W        (SEL_W)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (cfg_wr),
      .cfg_sel  (cfg_sel),
      .cfg_data (cfg_data),
      .station  (station_q),
      .hash_vec (hash_q),
      .mode     (mode_q)
   );

   rxf_hash #(
      .ADDR_W    (ADDR_W),
      .HASH_BITS (HASH_BITS)
   ) u_hash (
      .dst      (dst_addr),
      .hash_vec (hash_q),
      .hit      (hash_hit)
   );

   rxf_decide #(
      .ADDR_W  (ADDR_W),
      .LEN_W   (LEN_W),
      .MIN_LEN (MIN_LEN)
   ) u_dec (
      .dst       (dst_addr),
      .frame_len (frame_len),
      .crc_err   (crc_err),
      .align_err (align_err),
      .station   (station_q),
      .mode      (mode_q),
      .hash_hit  (hash_hit),
      .accept    (acc_d),
      .status    (status_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_accept <= 1'b0;
         res_status <= '0;
      end else begin
         res_valid  <= eof_valid;
         res_accept <= eof_valid & acc_d;
         res_status <= eof_valid ? status_d : '0;
      end
   end
endmodule

// File: rtl/rxf_addr_filter_chk.sv
`timescale 1ns/1ps
module rxf_addr_filter_chk
   import rxf_pkg::*;
#(
   parameter int ADDR_W  = 48,
   parameter int LEN_W   = 16,
   parameter int MIN_LEN = 64
)(
   input logic                clk,
   input logic                rst_n,
   input logic                eof_valid,
   input logic [ADDR_W-1:0]   dst_addr,
   input logic [LEN_W-1:0]    frame_len,
   input logic                crc_err,
   input logic                align_err,
   input logic [ADDR_W-1:0]   station,
   input rxf_mode_t           mode,
   input logic                res_valid,
   input logic                res_accept,
   input logic [STATUS_W-1:0] res_status
);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (!res_accept && res_status == '0));

   p_result_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      eof_valid |=> res_valid);

   p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !eof_valid |=> !res_valid);

   p_phys_mismatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_valid && !dst_addr[0] && !mode.promisc && dst_addr != station) |=> !res_accept);

   p_bcast_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_valid && (&dst_addr) && !mode.bc_en) |=> !res_accept);

   p_mcast_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_valid && dst_addr[0] && !(&dst_addr) && !mode.mc_en) |=> !res_accept);

   p_runt_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_valid && frame_len < LEN_W'(MIN_LEN) && !mode.runt_ok) |=> !res_accept);

   p_err_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_valid && (crc_err || align_err) && !mode.save_err) |=> !res_accept);

   p_align_implies_crc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_status[ST_ALIGN]) |-> res_status[ST_CRC]);

   p_group_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      eof_valid |=> (res_status[ST_GROUP] == $past(dst_addr[0])));
endmodule

bind rxf_addr_filter rxf_addr_filter_chk #(
   .ADDR_W  (ADDR_W),
   .LEN_W   (LEN_W),
   .MIN_LEN (MIN_LEN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .eof_valid  (eof_valid),
   .dst_addr   (dst_addr),
   .frame_len  (frame_len),
   .crc_err    (crc_err),
   .align_err  (align_err),
   .station    (station_q),
   .mode       (mode_q),
   .res_valid  (res_valid),
   .res_accept (res_accept),
   .res_status (res_status)
);

// File: tb/tb_rxf_addr_filter.sv
`timescale 1ns/1ps
module tb_rxf_addr_filter;
   localparam logic [47:0] STA = 48'h5544_3322_1102;
   localparam logic [47:0] OTH = 48'h6655_4433_2210;
   localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
   localparam logic [47:0] MC  = 48'h0000_005E_0001;
   localparam int NV = 24;

   // {mode[4:0], dst[47:0], len[15:0], crc, align, hash_all_ones, exp_accept}
   localparam logic [72:0] VECS [0:NV-1] = '{
      {5'h00, STA, 16'd64, 1'b0, 1'b0, 1'b0, 1'b1},
      {5'h00, OTH, 16'd64, 1'b0, 1'b0, 1'b0, 1'b0},
      {5'h04, OTH, 16'd64, 1'b0, 1'b0, 1'b0, 1'b1},
      {5'h00, BC,  16'd64, 1'b0, 1'b0, 1'b1, 1'b0},
      {5'h01, BC,  16'd64, 1'b0, 1'b0, 1'b0, 1'b1},
      {5'h02, MC,  16'd64, 1'b0, 1'b0, 1'b1, 1'b1},
      {5'h02, MC,  16'd64, 1'b0, 1'b0, 1'b0, 1'b0},
      {5'h00, MC,  16'd64, 1'b0, 1'b0, 1'b1, 1'b0},
      {5'h01, MC,  16'd64, 1'b0, 1'b0, 1'b1, 1'b0},
      {5'h02, BC,  16'd64, 1'b0, 1'b0, 1'b1, 1'b0},
      {5'h04, BC,  16'd64, 1'b0, 1'b0, 1'b1, 1'b0},
      {5'h04, MC,  16'd64, 1'b0, 1'b0, 1'b1, 1'b0},
      {5'h00, STA, 16'd60, 1'b0, 1'b0, 1'b0, 1'b0},
      {5'h08, STA, 16'd60, 1'b0, 1'b0, 1'b0, 1'b1},
      {5'h00, STA, 16'd63, 1'b0, 1'b0, 1'b0, 1'b0},
      {5'h00, STA, 16'd65, 1'b0, 1'b0, 1'b0, 1'b1},
      {5'h00, STA, 16'd64, 1'b1, 1'b0, 1'b0, 1'b0},
      {5'h10, STA, 16'd64, 1'b1, 1'b0, 1'b0, 1'b1},
      {5'h00, STA, 16'd64, 1'b0, 1'b1, 1'b0, 1'b0},
      {5'h10, STA, 16'd64, 1'b0, 1'b1, 1'b0, 1'b1},
      {5'h10, STA, 16'd60, 1'b1, 1'b0, 1'b0, 1'b0},
      {5'h1F, OTH, 16'd60, 1'b1, 1'b1, 1'b1, 1'b1},
      {5'h1F, BC,  16'd20, 1'b1, 1'b1, 1'b0, 1'b1},
      {5'h0B, MC,  16'd0,  1'b0, 1'b0, 1'b1, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [4:0]  cfg_sel = '0;
   logic [7:0]  cfg_data = '0;
   logic        eof_valid = 1'b0;
   logic [47:0] dst_addr = '0;
   logic [15:0] frame_len = '0;
   logic        crc_err = 1'b0;
   logic        align_err = 1'b0;
   logic        res_valid;
   logic        res_accept;
   logic [7:0]  res_status;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   rxf_addr_filter dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .eof_valid(eof_valid), .dst_addr(dst_addr), .frame_len(frame_len),
      .crc_err(crc_err), .align_err(align_err),
      .res_valid(res_valid), .res_accept(res_accept), .res_status(res_status)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [4:0] sel, input logic [7:0] data);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = sel; cfg_data = data;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic set_station(input logic [47:0] a);
      for (int k = 0; k < 6; k++) cfg_write(5'(k), a[8*k +: 8]);
   endtask

   task automatic set_hash_fill(input logic [7:0] v);
      for (int j = 0; j < 8; j++) cfg_write(5'(8 + j), v);
   endtask

   function automatic logic [5:0] ref_bin(input logic [47:0] a);
      logic [31:0] c;
      c = '1;
      for (int i = 0; i < 48; i++) begin
         logic fb;
         fb = c[0] ^ a[i];
         c = c >> 1;
         if (fb) c = c ^ 32'hEDB88320;
      end
      return {c[0], c[1], c[2], c[3], c[4], c[5]};
   endfunction

   // Expected status byte per R9.
   function automatic logic [7:0] ref_status(input logic acc, input logic [47:0] a,
                                             input logic [15:0] len, input logic ce, input logic ae);
      logic [7:0] s;
      s = '0;
      s[0] = acc & ~(ce | ae);
      s[1] = ce | ae;
      s[2] = ae;
      s[3] = (len < 16'd64);
      s[4] = a[0];
      return s;
   endfunction

   // Present one frame; check the result one clock later, then the idle cycle (R2).
   task automatic frame(input string req, input logic [47:0] a, input logic [15:0] len,
                        input logic ce, input logic ae, input logic exp_acc);
      @(negedge clk);
      eof_valid = 1'b1; dst_addr = a; frame_len = len; crc_err = ce; align_err = ae;
      @(negedge clk);
      eof_valid = 1'b0;
      chk("R2 valid", {31'b0, res_valid}, 32'd1);
      chk(req, {31'b0, res_accept}, {31'b0, exp_acc});
      chk("R9 status", {24'b0, res_status}, {24'b0, ref_status(exp_acc, a, len, ce, ae)});
      @(negedge clk);
      chk("R2 single pulse", {31'b0, res_valid}, 32'd0);
      chk("R2 idle accept", {31'b0, res_accept}, 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [5:0] bin;
      repeat (3) @(negedge clk);
      // R1: reset state of outputs
      chk("R1 valid", {31'b0, res_valid}, 32'd0);
      chk("R1 accept", {31'b0, res_accept}, 32'd0);
      chk("R1 status", {24'b0, res_status}, 32'd0);
      rst_n = 1'b1;
      // R1: station resets to zero, so destination zero matches
      frame("R1 station zero", 48'h0, 16'd64, 1'b0, 1'b0, 1'b1);
      // R1: mode resets to zero, so broadcast is dropped
      frame("R1 mode zero", BC, 16'd64, 1'b0, 1'b0, 1'b0);
      // R10: writes to unmapped indices change nothing
      cfg_write(5'd6, 8'hFF);
      cfg_write(5'd7, 8'hFF);
      cfg_write(5'd17, 8'hFF);
      cfg_write(5'd31, 8'hFF);
      frame("R10 unmapped station", 48'h0, 16'd64, 1'b0, 1'b0, 1'b1);
      frame("R10 unmapped mode", BC, 16'd64, 1'b0, 1'b0, 1'b0);
      cfg_write(5'd16, 8'h02);
      frame("R1 hash zero", MC, 16'd64, 1'b0, 1'b0, 1'b0);

      // Table walk: R3 R4 R5 R6 R7 R8
      set_station(STA);
      for (int v = 0; v < NV; v++) begin
         logic [72:0] e;
         e = VECS[v];
         cfg_write(5'd16, {3'b0, e[72:68]});
         set_hash_fill(e[1] ? 8'hFF : 8'h00);
         frame($sformatf("R3-7 vector %0d", v), e[67:20], e[19:4], e[3], e[2], e[0]);
      end

      // R6: only the computed bin set -> accepted; all other bins set -> rejected
      bin = ref_bin(MC);
      cfg_write(5'd16, 8'h02);
      for (int j = 0; j < 8; j++)
         cfg_write(5'(8 + j), (j == int'(bin[5:3])) ? (8'h01 << bin[2:0]) : 8'h00);
      frame("R6 single bin hit", MC, 16'd64, 1'b0, 1'b0, 1'b1);
      for (int j = 0; j < 8; j++)
         cfg_write(5'(8 + j), (j == int'(bin[5:3])) ? ~(8'h01 << bin[2:0]) : 8'hFF);
      frame("R6 single bin miss", MC, 16'd64, 1'b0, 1'b0, 1'b0);

      // R3: one differing bit in the last station byte
      cfg_write(5'd16, 8'h00);
      frame("R3 last byte mismatch", STA ^ 48'h8000_0000_0000, 16'd64, 1'b0, 1'b0, 1'b0);
      // R10: rewriting one station byte moves the match
      cfg_write(5'd5, 8'hD5);
      frame("R10 station byte 5", STA ^ 48'h8000_0000_0000, 16'd64, 1'b0, 1'b0, 1'b1);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule